// File: doc/BRIEF.md
# Beep Code Sequencer

This block turns an 8-bit test-point error code into an audible pattern on one speaker-enable line. When a start strobe is accepted, the code is cut into four 2-bit fields. Each field, plus one, gives a beep count from 1 to 4. The fields are played from the most significant pair down to the least significant, with a silent pause after each beep. The pause inside a group is short, and the pause after the last beep of a group is long. For example, code 16h sounds as 1-2-2-3.

A separate single-beep request plays exactly one beep and ignores the code. It is used when a lone short beep is wanted without any group encoding. The beep length, the gap between beeps and the gap between groups are parameters counted in clock cycles. Tone generation is left to whatever drives the speaker from the enable line.

Top module: `beep_code_player`

## Requirements
- R1: While `rst_n` is low at a clock edge, `beep_o`, `busy_o` and `done_o` are all 0 after that edge, and this holds even in the middle of a pattern. After reset is released, the block is idle and waits for a start strobe.
- R2: The beep count of group g (g = 0 first) is `code_i[7-2g:6-2g] + 1`. Groups play in order from g = 0 (bits 7:6) to g = 3 (bits 1:0).
- R3: Every beep holds `beep_o` high for exactly `BEEP_CYC` consecutive cycles.
- R4: Between two beeps of the same group, `beep_o` is low for exactly `BEEP_GAP_CYC` cycles.
- R5: After the last beep of every group, including the fourth, `beep_o` is low for exactly `GROUP_GAP_CYC` cycles.
- R6: `done_o` is high for exactly one cycle, the cycle right after the final group gap. `busy_o` is high from the first beep cycle through that done cycle, and low after it.
- R7: A start strobe that arrives while `busy_o` is high (including the done cycle) is ignored. `code_i` and `single_i` are sampled only when a start is accepted.
- R8: A start accepted with `single_i` = 1 plays one beep of `BEEP_CYC`, then a `GROUP_GAP_CYC` gap, then the done pulse, whatever `code_i` holds.
- R9: A start strobe seen at a clock edge while idle makes `beep_o` and `busy_o` high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only while idle |
| single_i | input | 1 | With start: play one lone beep instead of the code |
| code_i | input | 8 (NUM_GROUPS*FIELD_W) | Error code to play, sampled on an accepted start |
| beep_o | output | 1 | Speaker enable |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle pulse when the pattern is finished |

## Verification
All outputs are decoded from one state register.

- **First beep:** a start seen at edge k gives a high `beep_o` and `busy_o` in the cycle after edge k.
- **Run lengths:** each high or low run then lasts exactly its parameter's number of cycles.
- **Done pulse:** `done_o` follows the final group gap with no extra cycle.
- **Reset:** a reset edge clears every output at that edge.

The bench drives inputs and samples outputs on falling edges. From the code alone, it builds the expected sequence of run lengths and walks it cycle by cycle, starting at the first falling edge after the strobe. This way each run is checked for its exact length, and the done pulse is checked at its exact cycle.

// File: rtl/beep_code_pkg.sv
// Shared types for the beep code sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package beep_code_pkg;

    // Sequencer phases; every output of the block is decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start strobe
        ST_BEEP = 3'd1,   // speaker enabled
        ST_GAP  = 3'd2,   // short pause between beeps of one group
        ST_GGAP = 3'd3,   // long pause after the last beep of a group
        ST_FIN  = 3'd4    // one-cycle completion phase
    } seq_state_e;

endpackage

// File: rtl/beep_field_split.sv
// Splits the code into NUM_GROUPS fields of FIELD_W bits and turns each
// field into a one-based beep count. Entry 0 is the most significant field.
// Assumes: purely combinational; the caller latches the result.
module beep_field_split #(
    parameter int NUM_GROUPS = 4,
    parameter int FIELD_W    = 2,
    localparam int CODE_W    = NUM_GROUPS * FIELD_W,
    localparam int CNT_W     = FIELD_W + 1
) (
    input  logic [CODE_W-1:0]                 code_i,
    output logic [NUM_GROUPS-1:0][CNT_W-1:0]  count_o
);

    // One adder per field: the count is the field value plus one.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_field
        localparam int TOP = CODE_W - 1 - g * FIELD_W;
        assign count_o[g] = {1'b0, code_i[TOP -: FIELD_W]} + CNT_W'(1);
    end

endmodule

// File: rtl/beep_interval_timer.sv
// Down-counter that times one beep or one gap. A load sets the count to
// (duration - 1). expire_o is high during the last cycle of the interval.
// Assumes: the sequencer loads the timer on every phase change.
module beep_interval_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             expire_o
);

    logic [TMR_W-1:0] cnt_q;

    // Count register: reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TMR_W'(1);
        end
    end

    // The interval ends in the cycle where the count reaches zero.
    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/beep_sequencer.sv
// State machine that walks the groups and beeps and asks for the matching
// interval from the timer. It latches the counts and the mode when a start
// is accepted.
// Assumes: every duration parameter is at least 1, and the timer's expire
// flag reflects the most recent load.
module beep_sequencer
    import beep_code_pkg::*;
#(
    parameter int NUM_GROUPS    = 4,
    parameter int CNT_W         = 3,
    parameter int TMR_W         = 8,
    parameter int BEEP_CYC      = 4,
    parameter int BEEP_GAP_CYC  = 4,
    parameter int GROUP_GAP_CYC = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic                             single_i,
    input  logic [NUM_GROUPS-1:0][CNT_W-1:0] counts_i,
    input  logic                             expire_i,
    output logic                             tmr_load_o,
    output logic [TMR_W-1:0]                 tmr_val_o,
    output logic                             beep_o,
    output logic                             busy_o,
    output logic                             done_o
);

    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam logic [TMR_W-1:0] LD_BEEP = TMR_W'(BEEP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_GAP  = TMR_W'(BEEP_GAP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_GGAP = TMR_W'(GROUP_GAP_CYC - 1);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

    seq_state_e                       state_q, state_d;
    logic [GRP_W-1:0]                 grp_q, grp_d;
    logic [GRP_W-1:0]                 last_q, last_d;
    logic [CNT_W-1:0]                 left_q, left_d;
    logic [NUM_GROUPS-1:0][CNT_W-1:0] cnts_q, cnts_d;
    logic [GRP_W-1:0]                 grp_nxt;

    // Index of the group that follows the current one.
    assign grp_nxt = grp_q + GRP_W'(1);

    // Next-state logic and timer requests for every phase change.
    always_comb begin
        state_d    = state_q;
        grp_d      = grp_q;
        last_d     = last_q;
        left_d     = left_q;
        cnts_d     = cnts_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = LD_BEEP;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d    = ST_BEEP;
                    cnts_d     = counts_i;
                    grp_d      = '0;
                    last_d     = single_i ? '0 : LAST_GRP;
                    left_d     = single_i ? CNT_W'(1) : counts_i[0];
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LD_BEEP;
                end
            end
            ST_BEEP: begin
                if (expire_i) begin
                    tmr_load_o = 1'b1;
                    if (left_q > CNT_W'(1)) begin
                        state_d   = ST_GAP;
                        left_d    = left_q - CNT_W'(1);
                        tmr_val_o = LD_GAP;
                    end else begin
                        state_d   = ST_GGAP;
                        tmr_val_o = LD_GGAP;
                    end
                end
            end
            ST_GAP: begin
                if (expire_i) begin
                    state_d    = ST_BEEP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LD_BEEP;
                end
            end
            ST_GGAP: begin
                if (expire_i) begin
                    if (grp_q == last_q) begin
                        state_d = ST_FIN;
                    end else begin
                        state_d    = ST_BEEP;
                        grp_d      = grp_nxt;
                        left_d     = cnts_q[grp_nxt];
                        tmr_load_o = 1'b1;
                        tmr_val_o  = LD_BEEP;
                    end
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Sequencer registers; reset forces idle and silence at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            last_q  <= '0;
            left_q  <= '0;
            cnts_q  <= '0;
        end else begin
            state_q <= state_d;
            grp_q   <= grp_d;
            last_q  <= last_d;
            left_q  <= left_d;
            cnts_q  <= cnts_d;
        end
    end

    // Output decode straight from the state register, so no glitches.
    assign beep_o = (state_q == ST_BEEP);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_FIN);

endmodule

// File: rtl/beep_code_player.sv
// Top of the beep code sequencer: field split, sequencer and interval timer.
// Assumes: durations are given in clock cycles and are all at least 1;
// start_i is a level sampled at each edge and acted on only while idle.
module beep_code_player #(
    parameter int NUM_GROUPS    = 4,
    parameter int FIELD_W       = 2,
    parameter int BEEP_CYC      = 2_500_000,
    parameter int BEEP_GAP_CYC  = 2_500_000,
    parameter int GROUP_GAP_CYC = 7_500_000,
    localparam int CODE_W       = NUM_GROUPS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              single_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              beep_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W   = FIELD_W + 1;
    localparam int MAX_A   = (BEEP_CYC > BEEP_GAP_CYC) ? BEEP_CYC : BEEP_GAP_CYC;
    localparam int MAX_DUR = (MAX_A > GROUP_GAP_CYC) ? MAX_A : GROUP_GAP_CYC;
    localparam int TMR_W   = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1;

    logic [NUM_GROUPS-1:0][CNT_W-1:0] counts;
    logic                             tmr_load;
    logic [TMR_W-1:0]                 tmr_val;
    logic                             tmr_expire;

    // Field split: per-group one-based beep counts.
    beep_field_split #(
        .NUM_GROUPS (NUM_GROUPS),
        .FIELD_W    (FIELD_W)
    ) u_split (
        .code_i  (code_i),
        .count_o (counts)
    );

    // Sequencer: phases, group and beep bookkeeping.
    beep_sequencer #(
        .NUM_GROUPS    (NUM_GROUPS),
        .CNT_W         (CNT_W),
        .TMR_W         (TMR_W),
        .BEEP_CYC      (BEEP_CYC),
        .BEEP_GAP_CYC  (BEEP_GAP_CYC),
        .GROUP_GAP_CYC (GROUP_GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .single_i   (single_i),
        .counts_i   (counts),
        .expire_i   (tmr_expire),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .beep_o     (beep_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    // Interval timer shared by beeps and both kinds of gap.
    beep_interval_timer #(
        .TMR_W (TMR_W)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

endmodule

// File: rtl/beep_code_player_chk.sv
// Protocol checker for the beep code sequencer, attached with bind.
// Assumes: it sees only the top-level ports, and measures run lengths with
// counters so that no window depends on a large parameter.
module beep_code_player_chk #(
    parameter int BEEP_CYC      = 4,
    parameter int BEEP_GAP_CYC  = 4,
    parameter int GROUP_GAP_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic beep_o,
    input logic busy_o,
    input logic done_o
);

    logic rst_seen_q = 1'b0;
    logic beep_prev_q = 1'b0;
    logic played_q = 1'b0;
    int   hi_cnt_q = 0;
    int   lo_cnt_q = 0;

    // Remember that the last edge was a reset edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Measure high and low runs of the speaker enable within a pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beep_prev_q <= 1'b0;
            played_q    <= 1'b0;
            hi_cnt_q    <= 0;
            lo_cnt_q    <= 0;
        end else begin
            beep_prev_q <= beep_o;
            played_q    <= busy_o && (played_q || beep_o);
            hi_cnt_q    <= beep_o ? hi_cnt_q + 1 : 0;
            lo_cnt_q    <= beep_o ? 0 : lo_cnt_q + 1;
        end
    end

    // Immediate checks on reset effect and run lengths.
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            AST_RESET_QUIET: assert (!beep_o && !busy_o && !done_o)
                else $error("outputs active after reset edge"); // R1
        end
        if (rst_n && beep_prev_q && !beep_o) begin
            AST_BEEP_WIDTH: assert (hi_cnt_q == BEEP_CYC)
                else $error("beep width %0d", hi_cnt_q); // R3
        end
        if (rst_n && played_q && !beep_prev_q && beep_o) begin
            AST_GAP_WIDTH: assert (lo_cnt_q == BEEP_GAP_CYC || lo_cnt_q == GROUP_GAP_CYC)
                else $error("gap width %0d", lo_cnt_q); // R4
        end
    end

    AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && beep_o)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R6

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R6

    AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !beep_o); // R5

endmodule

bind beep_code_player beep_code_player_chk #(
    .BEEP_CYC      (BEEP_CYC),
    .BEEP_GAP_CYC  (BEEP_GAP_CYC),
    .GROUP_GAP_CYC (GROUP_GAP_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .beep_o  (beep_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/beep_code_player_tb.sv
// Directed bench for the beep code sequencer. Inputs are driven and
// outputs are sampled on falling edges.
module beep_code_player_tb;

    localparam int CLK_PERIOD = 10;
    localparam int L_BEEP = 3;
    localparam int L_GAP  = 2;
    localparam int L_GGAP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       single_i = 1'b0;
    logic [7:0] code_i = 8'h00;
    logic       beep_o, busy_o, done_o;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    beep_code_player #(
        .NUM_GROUPS    (4),
        .FIELD_W       (2),
        .BEEP_CYC      (L_BEEP),
        .BEEP_GAP_CYC  (L_GAP),
        .GROUP_GAP_CYC (L_GGAP)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .single_i (single_i),
        .code_i   (code_i),
        .beep_o   (beep_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record one check and report it on failure.
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Walk one expected run of beep_o; optionally strobe start in its first cycle.
    task automatic seg(input logic lvl, input int len, input bit poke, input string tag);
        int bad = 0;
        int act = lvl;
        for (int i = 0; i < len; i++) begin
            if (poke && i == 0) begin
                start_i = 1'b1; code_i = 8'hFF; single_i = 1'b1;
            end
            if (poke && i == 1) begin
                start_i = 1'b0; single_i = 1'b0;
            end
            if (beep_o !== lvl || busy_o !== 1'b1) begin
                if (bad == 0) act = beep_o;
                bad++;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        single_i = 1'b0;
        check(bad == 0, tag, act, lvl);
    endtask

    // Play one pattern and compare it with the sequence the requirements give.
    task automatic play(input logic [7:0] code, input bit single, input int poke_at,
                        input bit poke_done);
        int ngr;
        int run = 0;
        @(negedge clk);
        code_i = code; single_i = single; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; code_i = ~code; single_i = 1'b0;
        check(beep_o === 1'b1 && busy_o === 1'b1, "R9 first beep", beep_o, 1);
        ngr = single ? 1 : 4;
        for (int g = 0; g < ngr; g++) begin
            int n = single ? 1 : int'((code >> (6 - 2 * g)) & 8'h3) + 1;
            for (int b = 0; b < n; b++) begin
                seg(1'b1, L_BEEP, run == poke_at, single ? "R8 beep" : "R2/R3 beep");
                run++;
                if (b < n - 1) seg(1'b0, L_GAP, run == poke_at, "R4 gap");
                else           seg(1'b0, L_GGAP, run == poke_at, "R5 group gap");
                run++;
            end
        end
        check(done_o === 1'b1 && busy_o === 1'b1, "R6 done cycle", done_o, 1);
        if (poke_done) begin
            start_i = 1'b1; code_i = 8'hFF;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b0 && busy_o === 1'b0, "R6 after done", busy_o, 0);
        if (poke_done) begin
            int busy_seen = 0;
            for (int i = 0; i < 4; i++) begin
                if (busy_o !== 1'b0 || beep_o !== 1'b0) busy_seen++;
                @(negedge clk);
            end
            check(busy_seen == 0, "R7 start on done ignored", busy_seen, 0);
        end
    endtask

    // Scenario: reset state right after power-up reset.
    task automatic t_reset_state();
        check(beep_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
              "R1 reset state", {beep_o, busy_o, done_o}, 0);
    endtask

    // Scenario: reset in the middle of a pattern silences the output.
    task automatic t_reset_mid();
        int quiet_bad = 0;
        @(negedge clk);
        code_i = 8'hFF; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(beep_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
              "R1 reset mid pattern", {beep_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (beep_o !== 1'b0 || busy_o !== 1'b0) quiet_bad++;
            @(negedge clk);
        end
        check(quiet_bad == 0, "R1 idle after reset", quiet_bad, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        play(8'h16, 1'b0, -1, 1'b0);   // 1-2-2-3
        play(8'h00, 1'b0, -1, 1'b0);   // 1-1-1-1
        play(8'hFF, 1'b0, -1, 1'b0);   // 4-4-4-4
        play(8'h8D, 1'b0, -1, 1'b0);   // 3-1-4-2
        play(8'hFF, 1'b1, -1, 1'b0);   // lone beep, R8
        play(8'h00, 1'b0, 1, 1'b1);    // R7: strobes while busy and on done
        play(8'h4B, 1'b0, 2, 1'b0);    // R7: strobe during a beep, 2-1-3-4
        t_reset_mid();
        play(8'hC6, 1'b0, -1, 1'b0);   // 4-1-2-3 after reset
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule